// File: doc/BRIEF.md
# SPI Flash Transaction Monitor

This block is a passive observer for a serial flash bus running in clock mode 0. It never drives the bus. It oversamples the serial clock, the active-low select and the two data lines with a faster system clock. It rebuilds the bytes of each transaction, works out from the first byte which command is running, and follows that command's own byte sequence. The sequence covers the address bytes, any dummy byte, the data phase, and a switch to two bits per clock for the dual I/O read.

When the select line goes high again, the monitor issues one summary record. The record holds the opcode, the 24-bit address, the number of data bytes, the first data byte and four flag bits. Debug or trace logic can collect these records to see what firmware does with the flash, without storing the payload.

Top module: `spi_flash_sniffer`

## Requirements
- R1: Bits are sampled on rising SCLK edges while CS# is low, most significant bit first. The first complete byte on SIO0 is reported as the opcode. Each CS# rising edge that follows at least one complete byte produces exactly one record, marked by a recValid pulse one system clock wide.
- R2: Opcode 0x03 (read): bytes 2 to 4 from SIO0 form the address, most significant byte first. Every byte from byte 5 on is a data byte taken from SIO1. recCount is the number of data bytes and recFirst is the first of them.
- R3: Opcode 0x0B (fast read): byte 5 is a dummy byte and is not counted. Data bytes are taken from SIO1 starting at byte 6.
- R4: Opcode 0x02 (page program): data bytes are taken from SIO0 starting at byte 5. SIO1 is ignored.
- R5: Opcode 0xBB (dual read): after the opcode byte, each SCLK edge carries two bits. SIO1 carries bit positions 7, 5, 3, 1 and SIO0 carries positions 6, 4, 2, 0. In this format there are three address bytes, then one dummy byte, then data bytes.
- R6: Opcode 0x20 (sector erase): bytes 2 to 4 form the address. If the address is not a multiple of 4096, recFlags bit 2 is set. An erase reports a count of 0.
- R7: A sector erase with any byte after byte 4 sets recFlags bit 3 (overrun). Those extra bytes are not counted.
- R8: Any other opcode sets recFlags bit 0 (unknown). The record then carries address 0, count 0 and first byte 0.
- R9: If CS# rises on an addressed opcode before all three address bytes have arrived, recFlags bit 1 (truncated) is set. recAddr then holds the address bytes received so far, right-aligned.
- R10: A byte left incomplete when CS# rises is dropped. A CS# low period with no complete byte produces no record.
- R11: SCLK edges while CS# is high have no effect on any record.
- R12: After reset recValid is 0 and all record fields read 0. A record with a count of 0 reports recFirst as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the bus |
| csnIn | input | 1 | Active-low chip select from the bus |
| sio0In | input | 1 | Master-out line, also dual-mode even bits |
| sio1In | input | 1 | Slave-out line, also dual-mode odd bits |
| recValid | output | 1 | One-cycle strobe: a new record is on the rec* outputs |
| recOpcode | output | 8 | Command opcode |
| recAddr | output | 24 | Captured address |
| recCount | output | CNT_W | Number of data bytes (saturating) |
| recFirst | output | 8 | First data byte, 0 if none |
| recFlags | output | 4 | bit0 unknown, bit1 truncated, bit2 misaligned, bit3 overrun |

## Verification
The bench gives each command junk on the line it should ignore. A monitor that takes fast-read data one byte early, takes page-program data from SIO1, or unpacks dual bits in swapped order therefore reports the wrong recFirst or recCount. Erases are checked aligned, misaligned and with a trailing byte, so that an alignment test on the wrong address bits or a missing overrun flag shows up. Transactions that end after two address bytes, or that stop in the middle of a data byte, expose designs that leave out the truncated flag or count a partial byte. A burst of SCLK edges while CS# is high, and a select pulse that carries only a few bits, expose leakage between frames and records issued without cause.

// File: rtl/sniff_pkg.sv
`timescale 1ns/1ps
package sniff_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_FAST  = 8'h0B;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'h20;
  localparam logic [7:0] OP_DUAL  = 8'hBB;

  localparam int FLAG_UNKNOWN = 0;
  localparam int FLAG_TRUNC   = 1;
  localparam int FLAG_MISALN  = 2;
  localparam int FLAG_OVERRUN = 3;
  localparam int FLAG_W       = 4;

  typedef enum logic [2:0] {
    K_NONE, K_READ, K_FAST, K_DUAL, K_PROG, K_ERASE, K_OTHER
  } cmd_kind_e;

  typedef struct packed {
    logic              clear;
    logic              dual;
    logic              loadOp;
    logic              shiftAddr;
    logic              takeMosi;
    logic              takeMiso;
    logic              emit;
    logic [FLAG_W-1:0] flags;
  } sniff_strobe_t;
endpackage

// File: rtl/sniff_datapath.sv
`timescale 1ns/1ps
module sniff_datapath
  import sniff_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16,
  parameter int ADDR_BYTES  = 3,
  parameter int SECTOR_BITS = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclkIn,
  input  logic                csnIn,
  input  logic                sio0In,
  input  logic                sio1In,
  input  sniff_strobe_t       stb,
  output logic                byteDone,
  output logic [7:0]          byteMosi,
  output logic [7:0]          byteMiso,
  output logic                csFall,
  output logic                csRise,
  output logic                addrAligned,
  output logic                recValid,
  output logic [7:0]          recOpcode,
  output logic [ADDR_BYTES*8-1:0] recAddr,
  output logic [CNT_W-1:0]    recCount,
  output logic [7:0]          recFirst,
  output logic [FLAG_W-1:0]   recFlags
);
  localparam int ADDR_W = ADDR_BYTES * 8;
  localparam int TOP    = SYNC_STAGES - 1;

  logic [TOP:0] sclkSync, csSync, s0Sync, s1Sync;
  logic sclkPrev, csPrev;
  logic sclkS, csS, s0S, s1S, sample;
  logic [3:0] bitCnt, bitNext;
  logic [7:0] moSh, miSh, moNext, miNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0; csSync <= '1; s0Sync <= '0; s1Sync <= '0;
      sclkPrev <= 1'b0; csPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[TOP-1:0], sclkIn};
      csSync   <= {csSync[TOP-1:0], csnIn};
      s0Sync   <= {s0Sync[TOP-1:0], sio0In};
      s1Sync   <= {s1Sync[TOP-1:0], sio1In};
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  assign sclkS  = sclkSync[TOP];
  assign csS    = csSync[TOP];
  assign s0S    = s0Sync[TOP];
  assign s1S    = s1Sync[TOP];
  assign csFall = !csS && csPrev;
  assign csRise = csS && !csPrev;
  assign sample = sclkS && !sclkPrev && !csS;

  always_comb begin
    if (stb.dual) begin
      moNext  = {moSh[5:0], s1S, s0S};
      miNext  = moNext;
      bitNext = bitCnt + 4'd2;
    end else begin
      moNext  = {moSh[6:0], s0S};
      miNext  = {miSh[6:0], s1S};
      bitNext = bitCnt + 4'd1;
    end
  end

  assign byteDone = sample && (bitNext == 4'd8);
  assign byteMosi = moNext;
  assign byteMiso = miNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0; moSh <= '0; miSh <= '0;
    end else if (csFall || csRise) begin
      bitCnt <= '0;
    end else if (sample) begin
      moSh   <= moNext;
      miSh   <= miNext;
      bitCnt <= byteDone ? 4'd0 : bitNext;
    end
  end

  // Working record of the open transaction
  logic [7:0]        opW, firstW;
  logic [ADDR_W-1:0] addrW;
  logic [CNT_W-1:0]  countW;
  logic [7:0]        dataByte;

  assign dataByte    = stb.takeMosi ? byteMosi : byteMiso;
  assign addrAligned = (addrW[SECTOR_BITS-1:0] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opW <= '0; firstW <= '0; addrW <= '0; countW <= '0;
    end else if (stb.clear) begin
      opW <= '0; firstW <= '0; addrW <= '0; countW <= '0;
    end else begin
      if (stb.loadOp) opW <= byteMosi;
      if (stb.shiftAddr) addrW <= {addrW[ADDR_W-9:0], byteMosi};
      if (stb.takeMosi || stb.takeMiso) begin
        if (countW == '0) firstW <= dataByte;
        if (countW != '1) countW <= countW + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      recValid <= 1'b0; recOpcode <= '0; recAddr <= '0;
      recCount <= '0; recFirst <= '0; recFlags <= '0;
    end else begin
      recValid <= stb.emit;
      if (stb.emit) begin
        recOpcode <= opW;
        recAddr   <= addrW;
        recCount  <= countW;
        recFirst  <= firstW;
        recFlags  <= stb.flags;
      end
    end
  end

  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    recValid |=> !recValid);
  p_unknown_empty_r8: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recFlags[FLAG_UNKNOWN]) |-> (recCount == '0 && recAddr == '0));
  p_first_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recCount == '0) |-> (recFirst == '0));
endmodule

// File: rtl/sniff_control.sv
`timescale 1ns/1ps
module sniff_control
  import sniff_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          byteDone,
  input  logic [7:0]    byteMosi,
  input  logic          csFall,
  input  logic          csRise,
  input  logic          addrAligned,
  output sniff_strobe_t stb
);
  cmd_kind_e  kind;
  logic       active, overrun;
  logic [2:0] idx;
  logic       addressed;

  function automatic cmd_kind_e decodeOp(input logic [7:0] op);
    case (op)
      OP_READ:  return K_READ;
      OP_FAST:  return K_FAST;
      OP_DUAL:  return K_DUAL;
      OP_PROG:  return K_PROG;
      OP_ERASE: return K_ERASE;
      default:  return K_OTHER;
    endcase
  endfunction

  assign addressed = (kind != K_NONE) && (kind != K_OTHER);

  always_comb begin
    stb       = '0;
    stb.clear = csFall;
    stb.dual  = (kind == K_DUAL);
    if (byteDone) begin
      if (idx == 3'd0) stb.loadOp = 1'b1;
      else if (addressed && idx <= 3'd3) stb.shiftAddr = 1'b1;
      else begin
        case (kind)
          K_READ: stb.takeMiso = (idx >= 3'd4);
          K_FAST: stb.takeMiso = (idx >= 3'd5);
          K_DUAL: stb.takeMosi = (idx >= 3'd5);
          K_PROG: stb.takeMosi = (idx >= 3'd4);
          default: ;
        endcase
      end
    end
    stb.emit                = csRise && active && (idx != 3'd0);
    stb.flags[FLAG_UNKNOWN] = (kind == K_OTHER);
    stb.flags[FLAG_TRUNC]   = addressed && (idx < 3'd4);
    stb.flags[FLAG_MISALN]  = (kind == K_ERASE) && (idx >= 3'd4) && !addrAligned;
    stb.flags[FLAG_OVERRUN] = overrun;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind <= K_NONE; active <= 1'b0; overrun <= 1'b0; idx <= '0;
    end else if (csFall) begin
      kind <= K_NONE; active <= 1'b1; overrun <= 1'b0; idx <= '0;
    end else if (csRise) begin
      active <= 1'b0;
    end else if (byteDone) begin
      if (idx != 3'd7) idx <= idx + 3'd1;
      if (idx == 3'd0) kind <= decodeOp(byteMosi);
      if (kind == K_ERASE && idx >= 3'd4) overrun <= 1'b1;
    end
  end

  p_byte_in_frame_r11: assert property (@(posedge clk) disable iff (!rstN)
    byteDone |-> (active || csFall));
  p_dual_only_bb_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.dual |-> (idx != 3'd0 || !byteDone));
  p_overrun_erase_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> (kind == K_ERASE));
endmodule

// File: rtl/spi_flash_sniffer.sv
`timescale 1ns/1ps
module spi_flash_sniffer
  import sniff_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkIn,
  input  logic             csnIn,
  input  logic             sio0In,
  input  logic             sio1In,
  output logic             recValid,
  output logic [7:0]       recOpcode,
  output logic [23:0]      recAddr,
  output logic [CNT_W-1:0] recCount,
  output logic [7:0]       recFirst,
  output logic [3:0]       recFlags
);
  sniff_strobe_t stb;
  logic byteDone, csFall, csRise, addrAligned;
  logic [7:0] byteMosi, byteMiso;

  sniff_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W), .ADDR_BYTES(3), .SECTOR_BITS(12)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn),
    .sio0In(sio0In), .sio1In(sio1In), .stb(stb),
    .byteDone(byteDone), .byteMosi(byteMosi), .byteMiso(byteMiso),
    .csFall(csFall), .csRise(csRise), .addrAligned(addrAligned),
    .recValid(recValid), .recOpcode(recOpcode), .recAddr(recAddr),
    .recCount(recCount), .recFirst(recFirst), .recFlags(recFlags)
  );

  sniff_control u_ctl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .byteMosi(byteMosi),
    .csFall(csFall), .csRise(csRise), .addrAligned(addrAligned), .stb(stb)
  );
endmodule

// File: tb/test_spi_flash_sniffer.sv
`timescale 1ns/1ps
module test_spi_flash_sniffer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, csnIn = 1'b1, sio0In = 1'b0, sio1In = 1'b0;
  logic recValid;
  logic [7:0] recOpcode, recFirst;
  logic [23:0] recAddr;
  logic [15:0] recCount;
  logic [3:0] recFlags;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic [15:0] cnt;
    logic [7:0]  first;
    logic [3:0]  flags;
  } exp_t;
  exp_t expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  spi_flash_sniffer i_spi_flash_sniffer (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .csnIn(csnIn),
    .sio0In(sio0In), .sio1In(sio1In), .recValid(recValid),
    .recOpcode(recOpcode), .recAddr(recAddr), .recCount(recCount),
    .recFirst(recFirst), .recFlags(recFlags)
  );

  task automatic check(string tag, string field, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: got 0x%0h expected 0x%0h", tag, field, act, exp);
    end
  endtask

  task automatic expect_rec(string tag, logic [7:0] op, logic [23:0] addr,
                            logic [15:0] cnt, logic [7:0] first, logic [3:0] flags);
    exp_t e;
    e.op = op; e.addr = addr; e.cnt = cnt; e.first = first; e.flags = flags;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && recValid) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected record", "recValid", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, "opcode", recOpcode, e.op);
        check(t, "addr", recAddr, e.addr);
        check(t, "count", recCount, e.cnt);
        check(t, "first", recFirst, e.first);
        check(t, "flags", recFlags, e.flags);
      end
    end
  end

  task automatic spiStart();
    csnIn = 1'b0;
    #40;
  endtask

  task automatic spiEnd();
    #40 csnIn = 1'b1;
    #200;
  endtask

  task automatic spiByte(logic [7:0] mo, logic [7:0] mi);
    for (int i = 7; i >= 0; i--) begin
      sio0In = mo[i]; sio1In = mi[i];
      #40 sclkIn = 1'b1;
      #40 sclkIn = 1'b0;
    end
  endtask

  task automatic spiBits(logic [7:0] mo, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sio0In = mo[i]; sio1In = ~mo[i];
      #40 sclkIn = 1'b1;
      #40 sclkIn = 1'b0;
    end
  endtask

  task automatic dualByte(logic [7:0] b);
    for (int k = 0; k < 4; k++) begin
      sio1In = b[7-2*k]; sio0In = b[6-2*k];
      #40 sclkIn = 1'b1;
      #40 sclkIn = 1'b0;
    end
  endtask

  task automatic sendAddr(logic [23:0] a);
    spiByte(a[23:16], 8'hFF);
    spiByte(a[15:8], 8'hFF);
    spiByte(a[7:0], 8'hFF);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R12: reset state
    check("R12 reset", "recValid", recValid, 0);
    check("R12 reset", "count", recCount, 0);
    check("R12 reset", "flags", recFlags, 0);
    check("R12 reset", "addr", recAddr, 0);
    rstN = 1'b1;
    #100;

    // R11: clock edges with CS# high, then a normal read (R1, R2)
    for (int i = 0; i < 5; i++) begin
      sio0In = 1'b1; sio1In = 1'b1;
      #40 sclkIn = 1'b1;
      #40 sclkIn = 1'b0;
    end
    expect_rec("R2 R11 read", 8'h03, 24'h123456, 16'd3, 8'hA5, 4'h0);
    spiStart(); spiByte(8'h03, 8'h00); sendAddr(24'h123456);
    spiByte(8'h00, 8'hA5); spiByte(8'h00, 8'h3C); spiByte(8'h00, 8'h7E);
    spiEnd();

    // R3: fast read, dummy carries junk on SIO1
    expect_rec("R3 fast read", 8'h0B, 24'h00ABCD, 16'd2, 8'h11, 4'h0);
    spiStart(); spiByte(8'h0B, 8'h00); sendAddr(24'h00ABCD);
    spiByte(8'h00, 8'hEE); spiByte(8'h00, 8'h11); spiByte(8'h00, 8'h22);
    spiEnd();

    // R4: page program takes SIO0
    expect_rec("R4 program", 8'h02, 24'h040100, 16'd4, 8'hDE, 4'h0);
    spiStart(); spiByte(8'h02, 8'h00); sendAddr(24'h040100);
    spiByte(8'hDE, 8'h99); spiByte(8'hAD, 8'h99);
    spiByte(8'hBE, 8'h99); spiByte(8'hEF, 8'h99);
    spiEnd();

    // R5: dual read
    expect_rec("R5 dual read", 8'hBB, 24'h7654AA, 16'd2, 8'hC3, 4'h0);
    spiStart(); spiByte(8'hBB, 8'h00);
    dualByte(8'h76); dualByte(8'h54); dualByte(8'hAA);
    dualByte(8'h00); dualByte(8'hC3); dualByte(8'h5A);
    spiEnd();

    // R6: erase aligned and misaligned
    expect_rec("R6 erase aligned", 8'h20, 24'h003000, 16'd0, 8'h00, 4'h0);
    spiStart(); spiByte(8'h20, 8'h00); sendAddr(24'h003000); spiEnd();
    expect_rec("R6 erase misaligned", 8'h20, 24'h003010, 16'd0, 8'h00, 4'h4);
    spiStart(); spiByte(8'h20, 8'h00); sendAddr(24'h003010); spiEnd();

    // R7: erase with trailing byte
    expect_rec("R7 erase overrun", 8'h20, 24'h005000, 16'd0, 8'h00, 4'h8);
    spiStart(); spiByte(8'h20, 8'h00); sendAddr(24'h005000);
    spiByte(8'h77, 8'h00); spiEnd();

    // R8: unknown opcode
    expect_rec("R8 unknown", 8'h9F, 24'h000000, 16'd0, 8'h00, 4'h1);
    spiStart(); spiByte(8'h9F, 8'h00); sendAddr(24'hC22017); spiEnd();

    // R9: truncated address
    expect_rec("R9 truncated", 8'h03, 24'h001234, 16'd0, 8'h00, 4'h2);
    spiStart(); spiByte(8'h03, 8'h00);
    spiByte(8'h12, 8'hFF); spiByte(8'h34, 8'hFF); spiEnd();

    // R10: partial data byte dropped
    expect_rec("R10 partial byte", 8'h03, 24'h000010, 16'd1, 8'h81, 4'h0);
    spiStart(); spiByte(8'h03, 8'h00); sendAddr(24'h000010);
    spiByte(8'h00, 8'h81); spiBits(8'hF0, 5); spiEnd();

    // R10: select pulse with only four bits yields no record
    spiStart(); spiBits(8'hA0, 4); spiEnd();

    // R1: back-to-back read after the empty pulse still framed correctly
    expect_rec("R1 framing", 8'h03, 24'hFFFFFF, 16'd1, 8'h00, 4'h0);
    spiStart(); spiByte(8'h03, 8'h00); sendAddr(24'hFFFFFF);
    spiByte(8'hFF, 8'h00); spiEnd();

    #400;
    check("R10 pending records", "queue", expQ.size(), 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule